// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block drives the parallel control-register port of a set of PHYs. Each PHY has its own group of lines: select, address, write data, write enable, read enable, read data and acknowledge. A single command (PHY index, register address, write data, direction) is carried out with a four-phase handshake. The block raises the enable, waits for the acknowledge to go high, drops the enable, and then waits for the acknowledge to go low again. Both waits are bounded. The acknowledge is sampled only at poll instants, and there is a fixed number of them. If the acknowledge does not arrive in time, the enable is withdrawn and the operation ends with an error.

The block contains a lane-initialisation sweep, which a single start pulse launches. It writes one fixed configuration word to the configuration register of every lane of every PHY, one lane at a time. The sweep stops at the first access that times out. Before the first register access after reset, the block raises the select line of every PHY and waits a settling time. The selects then stay high. Poll spacing and settling time are given in microseconds and converted to clock cycles from the `CLK_HZ` parameter.

Top module: `phyreg_master`

## Requirements
- R1: After reset `busy`, `done`, `err`, every select, every write enable and every read enable are low, and `rd_data` is 0.
- R2: No enable rises before every PHY's select is high and has been high for at least SETTLE_CYC = CLK_HZ/1e6 × SETTLE_US cycles. Once raised, the selects stay high.
- R3: A write drives the target PHY's address and write data, then raises its write enable. Once acknowledge is seen high, write enable drops. Once acknowledge is seen low, `done` pulses with `err` low. Address and write data stay stable while an enable is high.
- R4: A read raises read enable and captures the PHY's read data at the poll that sees acknowledge high. The captured value appears on `rd_data` by the `done` pulse. `rd_data` is not changed by writes, or by reads whose acknowledge never rises.
- R5: Acknowledge is sampled at poll instants spaced POLL_CYC = CLK_HZ/1e6 × POLL_US cycles. The first poll is in the first cycle of a wait phase, and there are at most MAX_POLLS (10) polls. An acknowledge present at any of them completes the phase.
- R6: If acknowledge is not seen high by the last poll, the operation times out. The enable is low by the `done` cycle, and `err` is high with `done`. `err` rises only together with `done`.
- R7: The poll count restarts at the start of the falling-acknowledge phase. If acknowledge is not seen low by its last poll, `done` pulses with `err` high.
- R8: A command is accepted only in a cycle where `busy` is low. `cmd_valid` while busy has no effect. `busy` is high from the cycle after acceptance through the single-cycle `done` pulse, and low in the cycle after it.
- R9: At most one enable (write or read, over all PHYs) is high at any time, and only the addressed PHY's enable is raised.
- R10: `init_start` while idle writes 0x0E21 (bits 0, 5, 9, 10 and 11 set) to address 0x1008 + 0x100 × lane. It covers lanes 0..LANES-1 in ascending order, first on PHY 0 and then on each higher PHY. A single `done` pulse with `err` low ends the sweep.
- R11: A timeout inside the sweep ends it at once, with one `done` pulse and `err` high. No further lane is accessed.
- R12: If `init_start` and `cmd_valid` are both high in an idle cycle, the sweep starts and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_phy | input | clog2(NPHY) | Target PHY index |
| cmd_addr | input | 16 | Register address |
| cmd_wdata | input | 16 | Write data |
| init_start | input | 1 | Launch the lane-initialisation sweep |
| busy | output | 1 | Operation or sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag of the last operation, held until the next acceptance |
| rd_data | output | 16 | Data of the last successful read |
| phy_sel | output | NPHY | Per-PHY select |
| phy_addr | output | NPHY×16 | Per-PHY address |
| phy_wdata | output | NPHY×16 | Per-PHY write data |
| phy_wen | output | NPHY | Per-PHY write enable |
| phy_ren | output | NPHY | Per-PHY read enable |
| phy_rdata | input | NPHY×16 | Per-PHY read data |
| phy_ack | input | NPHY | Per-PHY acknowledge |

## Verification
The assertions assume that acknowledge and read data are synchronous to `clk`, and that a PHY changes its acknowledge only in answer to its own enable. They also assume `rst` is held for at least one edge before use. The bench stands in for the PHYs with a responder that follows these rules. Its delays for raising and dropping acknowledge, and its never-acknowledge and stuck-high modes, are changed only between operations, while the block is idle. Commands and sweep starts are driven on the falling clock edge, so every input is settled at the edge that samples it.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

    localparam int PR_ADDR_W = 16;
    localparam int PR_DATA_W = 16;
    localparam int PR_PHY_W  = 4;

    // lane configuration register placement
    localparam logic [PR_ADDR_W-1:0] LANE_CFG_BASE   = 16'h1008;
    localparam logic [PR_ADDR_W-1:0] LANE_CFG_STRIDE = 16'h0100;

    // lane configuration word bit positions
    localparam int LB_CDR_TRACK = 0;
    localparam int LB_LOS_LEVEL = 5;
    localparam int LB_TERM_ON   = 9;
    localparam int LB_TERM_ACDC = 10;
    localparam int LB_LANE_ON   = 11;

    typedef struct packed {
        logic                 write;
        logic [PR_PHY_W-1:0]  phy;
        logic [PR_ADDR_W-1:0] addr;
        logic [PR_DATA_W-1:0] wdata;
    } phy_op_t;

    typedef enum logic [2:0] {
        ENG_IDLE, ENG_SETTLE, ENG_RAISE, ENG_WAIT_HI, ENG_WAIT_LO, ENG_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        SEQ_IDLE, SEQ_ISSUE, SEQ_WAIT
    } seq_state_t;

    function automatic logic [PR_DATA_W-1:0] lane_cfg_word();
        logic [PR_DATA_W-1:0] w;
        w = '0;
        w[LB_CDR_TRACK] = 1'b1;
        w[LB_LOS_LEVEL] = 1'b1;
        w[LB_TERM_ON]   = 1'b1;
        w[LB_TERM_ACDC] = 1'b1;
        w[LB_LANE_ON]   = 1'b1;
        return w;
    endfunction

    function automatic logic [PR_ADDR_W-1:0] lane_cfg_addr(input int unsigned lane);
        return PR_ADDR_W'(LANE_CFG_BASE + PR_ADDR_W'(lane) * LANE_CFG_STRIDE);
    endfunction

    function automatic int us_to_cycles(input int hz, input int us);
        int c;
        c = (hz / 1_000_000) * us;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/phyreg_poll_timer.sv
module phyreg_poll_timer #(
    parameter int PERIOD = 1000,
    parameter int POLLS  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic poll_now,
    output logic exhausted
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int NW = $clog2(POLLS + 1);

    logic [CW-1:0] cyc;
    logic [NW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cyc <= '0;
            cnt <= '0;
        end else if (cyc == CW'(PERIOD - 1)) begin
            cyc <= '0;
            if (cnt != NW'(POLLS)) cnt <= cnt + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    assign poll_now  = (cyc == '0) && (cnt != NW'(POLLS));
    assign exhausted = (cyc == '0) && (cnt == NW'(POLLS));
endmodule

// File: rtl/phyreg_hs_engine.sv
module phyreg_hs_engine
    import phyreg_pkg::*;
#(
    parameter int NPHY       = 2,
    parameter int SETTLE_CYC = 100
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req,
    input  phy_op_t                   req_op,
    input  logic                      poll_now,
    input  logic                      exhausted,
    output logic                      tmr_clr,
    output logic                      busy,
    output logic                      done,
    output logic                      err,
    output logic [PR_DATA_W-1:0]      rdata,
    output logic [NPHY-1:0]           phy_sel,
    output logic [NPHY*PR_ADDR_W-1:0] phy_addr,
    output logic [NPHY*PR_DATA_W-1:0] phy_wdata,
    output logic [NPHY-1:0]           phy_wen,
    output logic [NPHY-1:0]           phy_ren,
    input  logic [NPHY*PR_DATA_W-1:0] phy_rdata,
    input  logic [NPHY-1:0]           phy_ack
);
    localparam int PW = (NPHY > 1) ? $clog2(NPHY) : 1;
    localparam int SW = $clog2(SETTLE_CYC + 1);

    eng_state_t           state;
    phy_op_t              cur;
    logic                 sel_on, en_wr, en_rd;
    logic [SW-1:0]        settle_cnt;
    logic [PR_DATA_W-1:0] rd_arr [NPHY];
    logic                 ack_sel, ack_hit;

    generate
        for (genvar p = 0; p < NPHY; p++) begin : g_phy
            logic hit;
            assign hit = (cur.phy == PR_PHY_W'(p));
            assign phy_sel[p] = sel_on;
            assign phy_wen[p] = en_wr && hit;
            assign phy_ren[p] = en_rd && hit;
            assign phy_addr[p*PR_ADDR_W +: PR_ADDR_W]  = hit ? cur.addr  : '0;
            assign phy_wdata[p*PR_DATA_W +: PR_DATA_W] = hit ? cur.wdata : '0;
            assign rd_arr[p] = phy_rdata[p*PR_DATA_W +: PR_DATA_W];
        end
    endgenerate

    assign ack_sel = phy_ack[cur.phy[PW-1:0]];
    assign ack_hit = (state == ENG_WAIT_HI) && !exhausted && poll_now && ack_sel;
    assign tmr_clr = (state == ENG_RAISE) || ack_hit;
    assign busy    = (state != ENG_IDLE);
    assign done    = (state == ENG_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            cur        <= '0;
            sel_on     <= 1'b0;
            en_wr      <= 1'b0;
            en_rd      <= 1'b0;
            settle_cnt <= '0;
            rdata      <= '0;
            err        <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: if (req) begin
                    cur <= req_op;
                    err <= 1'b0;
                    if (sel_on) begin
                        state <= ENG_RAISE;
                    end else begin
                        sel_on     <= 1'b1;
                        settle_cnt <= '0;
                        state      <= ENG_SETTLE;
                    end
                end
                ENG_SETTLE: begin
                    if (settle_cnt == SW'(SETTLE_CYC - 1)) state <= ENG_RAISE;
                    else settle_cnt <= settle_cnt + 1'b1;
                end
                ENG_RAISE: begin
                    en_wr <= cur.write;
                    en_rd <= !cur.write;
                    state <= ENG_WAIT_HI;
                end
                ENG_WAIT_HI: begin
                    if (exhausted) begin
                        en_wr <= 1'b0;
                        en_rd <= 1'b0;
                        err   <= 1'b1;
                        state <= ENG_DONE;
                    end else if (ack_hit) begin
                        if (!cur.write) rdata <= rd_arr[cur.phy[PW-1:0]];
                        en_wr <= 1'b0;
                        en_rd <= 1'b0;
                        state <= ENG_WAIT_LO;
                    end
                end
                ENG_WAIT_LO: begin
                    if (exhausted) begin
                        err   <= 1'b1;
                        state <= ENG_DONE;
                    end else if (poll_now && !ack_sel) begin
                        state <= ENG_DONE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phyreg_lane_seq.sv
module phyreg_lane_seq
    import phyreg_pkg::*;
#(
    parameter int NPHY  = 2,
    parameter int LANES = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    op_done,
    input  logic    op_err,
    output logic    active,
    output logic    req,
    output phy_op_t req_op,
    output logic    finish
);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    seq_state_t          state;
    logic [PR_PHY_W-1:0] phy_i;
    logic [LW-1:0]       lane_i;
    logic                last_lane, last;

    assign last_lane = (lane_i == LW'(LANES - 1));
    assign last      = last_lane && (phy_i == PR_PHY_W'(NPHY - 1));
    assign active    = (state != SEQ_IDLE);
    assign req       = (state == SEQ_ISSUE);
    assign finish    = (state == SEQ_WAIT) && op_done && (op_err || last);

    always_comb begin
        req_op.write = 1'b1;
        req_op.phy   = phy_i;
        req_op.addr  = lane_cfg_addr(int'(lane_i));
        req_op.wdata = lane_cfg_word();
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            phy_i  <= '0;
            lane_i <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    phy_i  <= '0;
                    lane_i <= '0;
                    state  <= SEQ_ISSUE;
                end
                SEQ_ISSUE: state <= SEQ_WAIT;
                SEQ_WAIT: if (op_done) begin
                    if (op_err || last) begin
                        state <= SEQ_IDLE;
                    end else begin
                        state <= SEQ_ISSUE;
                        if (last_lane) begin
                            lane_i <= '0;
                            phy_i  <= phy_i + 1'b1;
                        end else begin
                            lane_i <= lane_i + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phyreg_master.sv
module phyreg_master
    import phyreg_pkg::*;
#(
    parameter int NPHY      = 2,
    parameter int LANES     = 4,
    parameter int CLK_HZ    = 100_000_000,
    parameter int POLL_US   = 10,
    parameter int SETTLE_US = 1,
    parameter int MAX_POLLS = 10,
    parameter int INIT_EN   = 1
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cmd_valid,
    input  logic                                  cmd_write,
    input  logic [((NPHY>1)?$clog2(NPHY):1)-1:0]  cmd_phy,
    input  logic [15:0]                           cmd_addr,
    input  logic [15:0]                           cmd_wdata,
    input  logic                                  init_start,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  err,
    output logic [15:0]                           rd_data,
    output logic [NPHY-1:0]                       phy_sel,
    output logic [NPHY*16-1:0]                    phy_addr,
    output logic [NPHY*16-1:0]                    phy_wdata,
    output logic [NPHY-1:0]                       phy_wen,
    output logic [NPHY-1:0]                       phy_ren,
    input  logic [NPHY*16-1:0]                    phy_rdata,
    input  logic [NPHY-1:0]                       phy_ack
);
    localparam int POLL_CYC   = us_to_cycles(CLK_HZ, POLL_US);
    localparam int SETTLE_CYC = us_to_cycles(CLK_HZ, SETTLE_US);

    logic    eng_busy, eng_done, tmr_clr, poll_now, exhausted;
    logic    seq_active, seq_req, seq_finish, idle, cmd_take, eng_req;
    phy_op_t seq_op, cmd_op, eng_op;

    assign idle     = !eng_busy && !seq_active;
    assign cmd_take = idle && cmd_valid && !((INIT_EN != 0) && init_start);
    assign cmd_op   = '{write: cmd_write, phy: PR_PHY_W'(cmd_phy),
                        addr: cmd_addr, wdata: cmd_wdata};
    assign eng_req  = seq_req || cmd_take;
    assign eng_op   = seq_req ? seq_op : cmd_op;
    assign busy     = eng_busy || seq_active;
    assign done     = seq_active ? seq_finish : eng_done;

    phyreg_poll_timer #(.PERIOD(POLL_CYC), .POLLS(MAX_POLLS)) u_timer (
        .clk(clk), .rst(rst), .clr(tmr_clr),
        .poll_now(poll_now), .exhausted(exhausted)
    );

    phyreg_hs_engine #(.NPHY(NPHY), .SETTLE_CYC(SETTLE_CYC)) u_engine (
        .clk(clk), .rst(rst), .req(eng_req), .req_op(eng_op),
        .poll_now(poll_now), .exhausted(exhausted), .tmr_clr(tmr_clr),
        .busy(eng_busy), .done(eng_done), .err(err), .rdata(rd_data),
        .phy_sel(phy_sel), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_wen(phy_wen), .phy_ren(phy_ren),
        .phy_rdata(phy_rdata), .phy_ack(phy_ack)
    );

    generate
        if (INIT_EN != 0) begin : g_seq
            phyreg_lane_seq #(.NPHY(NPHY), .LANES(LANES)) u_seq (
                .clk(clk), .rst(rst), .start(idle && init_start),
                .op_done(eng_done), .op_err(err),
                .active(seq_active), .req(seq_req), .req_op(seq_op),
                .finish(seq_finish)
            );
        end else begin : g_noseq
            assign seq_active = 1'b0;
            assign seq_req    = 1'b0;
            assign seq_op     = '0;
            assign seq_finish = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/phyreg_master_chk.sv
module phyreg_master_chk #(
    parameter int NPHY = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [NPHY-1:0]    phy_sel,
    input logic [NPHY*16-1:0] phy_addr,
    input logic [NPHY*16-1:0] phy_wdata,
    input logic [NPHY-1:0]    phy_wen,
    input logic [NPHY-1:0]    phy_ren
);
    logic any_en;
    assign any_en = |{phy_wen, phy_ren};

    assert_one_enable_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({phy_wen, phy_ren}));

    assert_enable_needs_sel_R2: assert property (@(posedge clk) disable iff (rst)
        any_en |-> (&phy_sel));

    assert_sel_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (&phy_sel) |=> (&phy_sel));

    assert_bus_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (any_en && $past(any_en)) |-> ($stable(phy_addr) && $stable(phy_wdata)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_through_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_err_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    assert_enables_low_at_done_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !any_en);
endmodule

bind phyreg_master phyreg_master_chk #(.NPHY(NPHY)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
    .phy_sel(phy_sel), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_wen(phy_wen), .phy_ren(phy_ren)
);

// File: tb/sim_phyreg_master.sv
module sim_phyreg_master;
    localparam int NPHY   = 2;
    localparam int LANES  = 4;
    localparam int CLK_HZ = 10_000_000;   // poll = 100 cycles, settle = 10 cycles
    localparam int SETTLE = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_write = 1'b0, init_start = 1'b0;
    logic [0:0]  cmd_phy = '0;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0;
    logic busy, done, err;
    logic [15:0] rd_data;
    logic [NPHY-1:0] phy_sel, phy_wen, phy_ren, phy_ack;
    logic [NPHY*16-1:0] phy_addr, phy_wdata, phy_rdata;

    always #5 clk = ~clk;

    phyreg_master #(.NPHY(NPHY), .LANES(LANES), .CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_phy(cmd_phy), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .init_start(init_start), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data), .phy_sel(phy_sel), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_wen(phy_wen), .phy_ren(phy_ren),
        .phy_rdata(phy_rdata), .phy_ack(phy_ack)
    );

    // ---------------- behavioural PHY responder ----------------
    int hi_dly = 3, lo_dly = 3;
    bit no_ack = 1'b0, stuck = 1'b0;
    int rcnt [NPHY];

    for (genvar p = 0; p < NPHY; p++) begin : g_rdata
        assign phy_rdata[p*16 +: 16] = phy_addr[p*16 +: 16] ^ 16'hA5A5 ^ 16'(p);
    end

    always @(posedge clk) begin
        for (int p = 0; p < NPHY; p++) begin
            if (rst) begin
                phy_ack[p] <= 1'b0;
                rcnt[p]    <= 0;
            end else if ((phy_wen[p] || phy_ren[p]) && !phy_ack[p]) begin
                if (!no_ack && rcnt[p] >= hi_dly) begin
                    phy_ack[p] <= 1'b1;
                    rcnt[p]    <= 0;
                end else rcnt[p] <= rcnt[p] + 1;
            end else if (!(phy_wen[p] || phy_ren[p]) && phy_ack[p]) begin
                if (!stuck && rcnt[p] >= lo_dly) begin
                    phy_ack[p] <= 1'b0;
                    rcnt[p]    <= 0;
                end else rcnt[p] <= rcnt[p] + 1;
            end else rcnt[p] <= 0;
        end
    end

    // ---------------- monitors ----------------
    logic [NPHY-1:0] en_q = '0;
    int sel_age = 0, sel_viol = 0, multi = 0, done_cnt = 0, log_n = 0;
    bit          log_wr   [64];
    int          log_phy  [64];
    logic [15:0] log_addr [64];
    logic [15:0] log_data [64];

    always @(posedge clk) begin
        for (int p = 0; p < NPHY; p++) begin
            if ((phy_wen[p] || phy_ren[p]) && !en_q[p] && log_n < 64) begin
                log_wr[log_n]   = phy_wen[p];
                log_phy[log_n]  = p;
                log_addr[log_n] = phy_addr[p*16 +: 16];
                log_data[log_n] = phy_wdata[p*16 +: 16];
                log_n = log_n + 1;
                if (sel_age < SETTLE) sel_viol = sel_viol + 1;
            end
        end
        en_q = phy_wen | phy_ren;
        if ($countones({phy_wen, phy_ren}) > 1) multi = multi + 1;
        if (done) done_cnt = done_cnt + 1;
        if (!(&phy_sel)) sel_age = 0;
        else if (sel_age < 1000) sel_age = sel_age + 1;
    end

    // ---------------- checking helpers ----------------
    int checks = 0, fails = 0, cyc = 0;
    bit ended = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic do_cmd(input bit wr, input int phy, input logic [15:0] a, input logic [15:0] d);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_phy = 1'(phy);
        cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
    endtask

    task automatic do_sweep();
        while (busy) @(negedge clk);
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
        wait_done();
    endtask

    function automatic logic [15:0] exp_rd(input logic [15:0] a, input int phy);
        return a ^ 16'hA5A5 ^ 16'(phy);
    endfunction

    // vectors: [33]=write [32]=phy [31:16]=addr [15:0]=wdata
    localparam logic [33:0] VECS [6] = '{
        {1'b1, 1'b0, 16'h0040, 16'h1234},
        {1'b0, 1'b0, 16'h0040, 16'h0000},
        {1'b1, 1'b1, 16'h0123, 16'hBEEF},
        {1'b0, 1'b1, 16'h0F00, 16'h0000},
        {1'b1, 1'b1, 16'hFFFF, 16'h0001},
        {1'b0, 1'b0, 16'h8001, 16'h0000}
    };

    logic [15:0] last_rd;
    int n0;

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && err == 0, "R1 status", {busy, done, err}, 0);
        check(phy_sel == 0 && phy_wen == 0 && phy_ren == 0, "R1 phy lines",
              {phy_sel, phy_wen, phy_ren}, 0);
        check(rd_data == 0, "R1 rd_data", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);

        last_rd = 16'h0;
        // table-driven main function (R3, R4, R9)
        for (int i = 0; i < 6; i++) begin
            n0 = log_n;
            do_cmd(VECS[i][33], int'(VECS[i][32]), VECS[i][31:16], VECS[i][15:0]);
            check(err == 0, "R3 no error on responsive PHY", err, 0);
            check(log_n == n0 + 1 && log_phy[n0] == int'(VECS[i][32]) &&
                  log_addr[n0] == VECS[i][31:16] && log_wr[n0] == VECS[i][33],
                  "R9 target and address", log_addr[n0], VECS[i][31:16]);
            if (VECS[i][33]) begin
                check(log_data[n0] == VECS[i][15:0], "R3 write data", log_data[n0], VECS[i][15:0]);
                check(rd_data == last_rd, "R4 rd_data kept over write", rd_data, last_rd);
            end else begin
                last_rd = exp_rd(VECS[i][31:16], int'(VECS[i][32]));
                check(rd_data == last_rd, "R4 read data", rd_data, last_rd);
            end
        end
        check(sel_viol == 0 && (&phy_sel), "R2 select before enable", sel_viol, 0);
        check(multi == 0, "R9 single enable", multi, 0);

        // R5/R7: late ack in both phases still succeeds (counter restarts)
        hi_dly = 850; lo_dly = 850;
        do_cmd(1'b0, 1, 16'h0222, 16'h0);
        last_rd = exp_rd(16'h0222, 1);
        check(err == 0, "R5 R7 ack before last poll", err, 0);
        check(rd_data == last_rd, "R5 late read data", rd_data, last_rd);

        // R6: ack too late for the rising phase
        hi_dly = 950; lo_dly = 3;
        do_cmd(1'b0, 0, 16'h0333, 16'h0);
        check(err == 1, "R6 rising timeout", err, 1);
        check(phy_wen == 0 && phy_ren == 0, "R6 enable low at done", {phy_wen, phy_ren}, 0);
        check(rd_data == last_rd, "R4 rd_data kept on timeout", rd_data, last_rd);
        hi_dly = 3;
        @(negedge clk);
        check(busy == 0, "R8 busy low after done", busy, 0);

        // R7: ack stuck high
        stuck = 1'b1;
        do_cmd(1'b1, 1, 16'h0444, 16'h5555);
        check(err == 1, "R7 falling timeout", err, 1);
        check(phy_wen == 0, "R7 enable low", phy_wen, 0);
        stuck = 1'b0;
        repeat (20) @(negedge clk);

        // R8: command while busy is ignored
        n0 = log_n;
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_phy = 1'b0;
        cmd_addr = 16'h0666; cmd_wdata = 16'h0A0A;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(busy == 1, "R8 busy during op", busy, 1);
        cmd_valid = 1'b1; cmd_addr = 16'h0777;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        repeat (300) @(negedge clk);
        check(log_n == n0 + 1 && log_addr[n0] == 16'h0666, "R8 busy command dropped",
              log_n - n0, 1);

        // R10: full sweep
        n0 = log_n;
        done_cnt = 0;
        do_sweep();
        @(negedge clk);
        check(err == 0 && done_cnt == 1, "R10 sweep single done", done_cnt, 1);
        check(log_n == n0 + NPHY * LANES, "R10 sweep count", log_n - n0, NPHY * LANES);
        for (int k = 0; k < NPHY * LANES; k++) begin
            logic [15:0] ea;
            ea = 16'h1008 + 16'h0100 * 16'(k % LANES);
            check(log_phy[n0+k] == k / LANES && log_addr[n0+k] == ea &&
                  log_data[n0+k] == 16'h0E21 && log_wr[n0+k],
                  "R10 lane order/word", {log_addr[n0+k], log_data[n0+k]}, {ea, 16'h0E21});
        end

        // R11: sweep aborts on first timeout
        n0 = log_n;
        done_cnt = 0;
        no_ack = 1'b1;
        do_sweep();
        repeat (300) @(negedge clk);
        check(err == 1 && done_cnt == 1, "R11 sweep abort", {err, 8'(done_cnt)}, 9'h101);
        check(log_n == n0 + 1, "R11 no further lanes", log_n - n0, 1);
        no_ack = 1'b0;

        // R12: sweep wins over simultaneous command
        n0 = log_n;
        while (busy) @(negedge clk);
        init_start = 1'b1; cmd_valid = 1'b1; cmd_write = 1'b1;
        cmd_addr = 16'h0555; cmd_phy = 1'b1;
        @(negedge clk);
        init_start = 1'b0; cmd_valid = 1'b0;
        wait_done();
        repeat (300) @(negedge clk);
        check(log_n == n0 + NPHY * LANES && log_addr[n0] == 16'h1008 && log_phy[n0] == 0,
              "R12 sweep priority", log_addr[n0], 16'h1008);
        check(multi == 0 && sel_viol == 0, "R9 R2 whole run", multi + sel_viol, 0);

        finish_run();
    end
endmodule